// File: doc/BRIEF.md
# Streaming Column-Wise Wavefront Reconstructor with Integral Servo

This block turns a stream of wavefront slope measurements into per-actuator drive values for a deformable mirror. It does not wait for the whole slope vector. Each slope is multiplied, in the cycle it arrives, by every coefficient of its column in the reconstruction matrix. All actuator lanes accumulate their products in parallel. The matrix product is therefore finished almost as soon as the last slope has been read from the sensor.

Once the programmed number of slopes has arrived, a per-actuator calibration offset is added to each accumulator to form the actuator error. Each error passes through a saturating integral servo. The error and the new drive value are then streamed out together, one actuator per cycle, so a downstream consumer can record per-frame loop statistics.

The matrix storage has two banks. One bank serves the frame in progress. The other takes background writes from an optimiser. A swap notification is held until the next frame begins.

Top module: `colwise_recon`

## Requirements
- R1: After reset, `frame_idle` is 1, `drv_valid` and `frame_done` are 0, `active_bank` is 0, and every integrator state is zero.
- R2: An accepted `frame_start` clears every accumulator. The k-th `slope_valid` beat of the frame (k counted from 0) is slope k. The error of an active actuator a is the sum, over k below `cfg_num_slopes`, of slope k times coefficient [active bank][k][a], plus calibration[a]. The calibration value is a signed 16-bit number written through `cal_wr_*`.
- R3: The drive of an active actuator is the previous drive plus floor(error × `cfg_gain` / 256), saturated to the signed 16-bit range [-32768, 32767]. `cfg_gain` is signed 12-bit with 8 fraction bits. The integrator state persists from frame to frame.
- R4: After the last slope, exactly `MAX_ACT` beats are emitted on consecutive cycles with `drv_idx` = 0, 1, …, `MAX_ACT`-1. Each beat carries that actuator's error and drive.
- R5: Actuators with index at or above `cfg_num_act` emit error 0 and drive 0. Their coefficients and calibration values have no effect on them.
- R6: Coefficient writes land in the bank that is not active, addressed by slope row and actuator column. Writes made during a frame do not change that frame's result.
- R7: A `mat_swap_req` pulse is held pending. It toggles `active_bank` only at the next accepted `frame_start`. Several requests before that start give a single toggle. `active_bank` never changes while a frame is in progress.
- R8: `frame_idle` falls at an accepted `frame_start` and rises again with `frame_done`. `frame_done` is a one-cycle pulse in the cycle after the last drive beat. A `frame_start` raised while not idle is ignored.
- R9: `slope_valid` beats while idle are ignored. Beats after `cfg_num_slopes` slopes have been taken in a frame are also ignored.
- R10: With `cfg_num_slopes` = 0, each active actuator's error equals its calibration value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_num_slopes | input | 5 | Slopes used per frame (0..MAX_SLOPES) |
| cfg_num_act | input | 5 | Actuators in closed loop (0..MAX_ACT) |
| cfg_gain | input | 12 | Signed servo gain, 8 fraction bits |
| mat_wr_en | input | 1 | Write one coefficient to the inactive bank |
| mat_wr_slope | input | 5 | Coefficient row (slope index) |
| mat_wr_act | input | 4 | Coefficient column (actuator index) |
| mat_wr_data | input | 12 | Signed coefficient |
| mat_swap_req | input | 1 | New-matrix notification pulse |
| cal_wr_en | input | 1 | Write one calibration offset |
| cal_wr_act | input | 4 | Calibration actuator index |
| cal_wr_data | input | 16 | Signed calibration offset |
| frame_start | input | 1 | Begin a frame (accepted only when idle) |
| frame_idle | output | 1 | Ready for a new frame |
| slope_valid | input | 1 | Slope beat present |
| slope_data | input | 12 | Signed slope value |
| drv_valid | output | 1 | Output beat present |
| drv_idx | output | 4 | Actuator index of the beat |
| err_data | output | 32 | Signed actuator error |
| drv_data | output | 16 | Signed servoed drive |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| active_bank | output | 1 | Matrix bank in use |

## Verification
The assertions check the structural behaviour on every cycle:
- the actuator index on the output advances by exactly one per beat and starts at zero;
- `frame_done` follows the last beat by one cycle;
- lanes outside the active range stay at zero;
- the bank select holds still for a whole frame;
- the slope counter never passes the programmed count;
- the accumulators are zero after a clear.

Only the bench scenarios can show that the numbers are right. They check the column-wise sums against an independent model, the floor and saturation of the integrator over several frames, and that background writes stay invisible until the next swap. They also check that stray or surplus slope beats and an early `frame_start` leave the results untouched.

// File: rtl/recon_pkg.sv
package recon_pkg;

  localparam int SLOPE_W   = 12;
  localparam int COEF_W    = 12;
  localparam int CAL_W     = 16;
  localparam int ACC_W     = 32;
  localparam int GAIN_W    = 12;
  localparam int GAIN_FRAC = 8;
  localparam int DRV_W     = 16;
  localparam int PROD_W    = ACC_W + GAIN_W;
  localparam int MUL_W     = SLOPE_W + COEF_W;

  typedef logic signed [SLOPE_W-1:0] slope_t;
  typedef logic signed [COEF_W-1:0]  coef_t;
  typedef logic signed [CAL_W-1:0]   cal_t;
  typedef logic signed [ACC_W-1:0]   acc_t;
  typedef logic signed [GAIN_W-1:0]  gain_t;
  typedef logic signed [DRV_W-1:0]   drv_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_OUT  = 2'd2,
    ST_FIN  = 2'd3
  } phase_e;

  // One column step: add slope x coefficient into a running sum.
  function automatic acc_t mac_step(acc_t acc, slope_t sl, coef_t cf);
    logic signed [MUL_W-1:0] p;
    p = sl * cf;
    return acc + ACC_W'(p);
  endfunction

  // Actuator error = accumulated product plus calibration offset.
  function automatic acc_t add_cal(acc_t acc, cal_t c);
    return acc + ACC_W'(c);
  endfunction

  // Integrator: prev + (err*gain) >>> GAIN_FRAC, clipped to the drive range.
  function automatic drv_t servo_step(drv_t prev, acc_t err, gain_t g);
    logic signed [PROD_W-1:0]       p;
    logic signed [PROD_W:0]         s;
    logic [PROD_W-DRV_W+1:0]        hi;
    p  = PROD_W'(err) * PROD_W'(g);
    s  = (PROD_W+1)'(p >>> GAIN_FRAC) + (PROD_W+1)'(prev);
    hi = s[PROD_W:DRV_W-1];
    if ((&hi) || !(|hi)) return s[DRV_W-1:0];
    else if (s[PROD_W])  return {1'b1, {(DRV_W-1){1'b0}}};
    else                 return {1'b0, {(DRV_W-1){1'b1}}};
  endfunction

endpackage

// File: rtl/recon_ctrl.sv
module recon_ctrl
  import recon_pkg::*;
#(
  parameter int MAX_SLOPES = 24,
  parameter int MAX_ACT    = 16,
  localparam int SI_W = $clog2(MAX_SLOPES),
  localparam int SN_W = $clog2(MAX_SLOPES + 1),
  localparam int AI_W = $clog2(MAX_ACT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            slope_valid,
  input  logic            swap_req,
  input  logic [SN_W-1:0] num_slopes,
  output logic            mac_en,
  output logic            clr_acc,
  output logic [SI_W-1:0] slope_idx,
  output logic            bank,
  output logic            out_en,
  output logic [AI_W-1:0] out_idx,
  output logic            frame_idle,
  output logic            frame_done
);

  phase_e          state_q;
  logic [SN_W-1:0] cnt_q;
  logic [AI_W-1:0] oidx_q;
  logic            bank_q, pend_q, done_q;
  logic [SN_W-1:0] eff_ns;
  logic            start_ok, cnt_full, last_out;

  assign eff_ns   = (num_slopes > SN_W'(MAX_SLOPES)) ? SN_W'(MAX_SLOPES) : num_slopes;
  assign start_ok = frame_start && (state_q == ST_IDLE);
  assign cnt_full = (cnt_q == eff_ns);
  assign last_out = (oidx_q == AI_W'(MAX_ACT - 1));

  assign mac_en     = (state_q == ST_ACC) && !cnt_full && slope_valid;
  assign clr_acc    = start_ok;
  assign slope_idx  = SI_W'(cnt_q);
  assign bank       = bank_q;
  assign out_en     = (state_q == ST_OUT);
  assign out_idx    = oidx_q;
  assign frame_idle = (state_q == ST_IDLE);
  assign frame_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      oidx_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_FIN);
      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          state_q <= ST_ACC;
          cnt_q   <= '0;
        end
        ST_ACC: begin
          if (cnt_full) begin
            state_q <= ST_OUT;
            oidx_q  <= '0;
          end else if (slope_valid) begin
            cnt_q <= cnt_q + SN_W'(1);
          end
        end
        ST_OUT: begin
          if (last_out) begin
            state_q <= ST_FIN;
            oidx_q  <= '0;
          end else begin
            oidx_q <= oidx_q + AI_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Swap notification is held and applied only when a frame is accepted.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (start_ok) begin
      if (pend_q) bank_q <= ~bank_q;
      pend_q <= swap_req;
    end else if (swap_req) begin
      pend_q <= 1'b1;
    end
  end

  AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(bank_q)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACC) |-> (cnt_q <= eff_ns)); // R9

endmodule

// File: rtl/recon_lane.sv
module recon_lane
  import recon_pkg::*;
#(
  parameter int MAX_SLOPES = 24,
  localparam int SI_W = $clog2(MAX_SLOPES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lane_on,
  input  logic            clr_acc,
  input  logic            mac_en,
  input  logic [SI_W-1:0] slope_idx,
  input  logic            rd_bank,
  input  slope_t          slope,
  input  logic            coef_we,
  input  logic            wr_bank,
  input  logic [SI_W-1:0] wr_slope,
  input  coef_t           wr_data,
  input  logic            cal_we,
  input  cal_t            cal_data,
  input  gain_t           gain,
  input  logic            upd_en,
  output acc_t            err,
  output drv_t            drv_next
);

  coef_t coef_mem [2][MAX_SLOPES];
  coef_t coef_rd;
  acc_t  acc_q;
  cal_t  cal_q;
  drv_t  drv_q;

  always_ff @(posedge clk) begin
    if (coef_we) coef_mem[wr_bank][wr_slope] <= wr_data;
  end

  assign coef_rd = coef_mem[rd_bank][slope_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)          acc_q <= '0;
    else if (clr_acc)    acc_q <= '0;
    else if (mac_en && lane_on) acc_q <= mac_step(acc_q, slope, coef_rd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cal_q <= '0;
    else if (cal_we) cal_q <= cal_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      drv_q <= '0;
    else if (upd_en) drv_q <= drv_next;
  end

  assign err      = lane_on ? add_cal(acc_q, cal_q) : '0;
  assign drv_next = lane_on ? servo_step(drv_q, err, gain) : '0;

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_acc) |-> (acc_q == '0)); // R2

endmodule

// File: rtl/colwise_recon.sv
module colwise_recon
  import recon_pkg::*;
#(
  parameter int MAX_SLOPES = 24,
  parameter int MAX_ACT    = 16,
  localparam int SI_W = $clog2(MAX_SLOPES),
  localparam int SN_W = $clog2(MAX_SLOPES + 1),
  localparam int AI_W = $clog2(MAX_ACT),
  localparam int AN_W = $clog2(MAX_ACT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SN_W-1:0]          cfg_num_slopes,
  input  logic [AN_W-1:0]          cfg_num_act,
  input  logic signed [GAIN_W-1:0] cfg_gain,
  input  logic                     mat_wr_en,
  input  logic [SI_W-1:0]          mat_wr_slope,
  input  logic [AI_W-1:0]          mat_wr_act,
  input  logic signed [COEF_W-1:0] mat_wr_data,
  input  logic                     mat_swap_req,
  input  logic                     cal_wr_en,
  input  logic [AI_W-1:0]          cal_wr_act,
  input  logic signed [CAL_W-1:0]  cal_wr_data,
  input  logic                     frame_start,
  output logic                     frame_idle,
  input  logic                     slope_valid,
  input  logic signed [SLOPE_W-1:0] slope_data,
  output logic                     drv_valid,
  output logic [AI_W-1:0]          drv_idx,
  output logic signed [ACC_W-1:0]  err_data,
  output logic signed [DRV_W-1:0]  drv_data,
  output logic                     frame_done,
  output logic                     active_bank
);

  logic            mac_en, clr_acc, bank, out_en;
  logic [SI_W-1:0] slope_idx;
  logic [AI_W-1:0] out_idx;

  acc_t lane_err [MAX_ACT];
  drv_t lane_drv [MAX_ACT];

  recon_ctrl #(.MAX_SLOPES(MAX_SLOPES), .MAX_ACT(MAX_ACT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .slope_valid(slope_valid),
    .swap_req   (mat_swap_req),
    .num_slopes (cfg_num_slopes),
    .mac_en     (mac_en),
    .clr_acc    (clr_acc),
    .slope_idx  (slope_idx),
    .bank       (bank),
    .out_en     (out_en),
    .out_idx    (out_idx),
    .frame_idle (frame_idle),
    .frame_done (frame_done)
  );

  for (genvar g = 0; g < MAX_ACT; g++) begin : g_lane
    logic on, cwe, kwe, upd;
    assign on  = (AN_W'(g) < cfg_num_act);
    assign cwe = mat_wr_en && (mat_wr_act == AI_W'(g));
    assign kwe = cal_wr_en && (cal_wr_act == AI_W'(g));
    assign upd = out_en && (out_idx == AI_W'(g));

    recon_lane #(.MAX_SLOPES(MAX_SLOPES)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .lane_on  (on),
      .clr_acc  (clr_acc),
      .mac_en   (mac_en),
      .slope_idx(slope_idx),
      .rd_bank  (bank),
      .slope    (slope_data),
      .coef_we  (cwe),
      .wr_bank  (~bank),
      .wr_slope (mat_wr_slope),
      .wr_data  (mat_wr_data),
      .cal_we   (kwe),
      .cal_data (cal_wr_data),
      .gain     (cfg_gain),
      .upd_en   (upd),
      .err      (lane_err[g]),
      .drv_next (lane_drv[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_valid <= 1'b0;
      drv_idx   <= '0;
      err_data  <= '0;
      drv_data  <= '0;
    end else begin
      drv_valid <= out_en;
      if (out_en) begin
        drv_idx  <= out_idx;
        err_data <= lane_err[out_idx];
        drv_data <= lane_drv[out_idx];
      end
    end
  end

  assign active_bank = bank;

  AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_valid && !$past(drv_valid)) |-> (drv_idx == '0)); // R4
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_valid && drv_idx != '0) |-> ($past(drv_valid) && ($past(drv_idx) == drv_idx - AI_W'(1)))); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(drv_valid) && ($past(drv_idx) == AI_W'(MAX_ACT - 1)))); // R8
  AST_QUIET_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_valid && (AN_W'(drv_idx) >= cfg_num_act)) |-> (err_data == '0 && drv_data == '0)); // R5

endmodule

// File: tb/colwise_recon_bench.sv
module colwise_recon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXS = 24;
  localparam int MAXA = 16;
  localparam int SI_W = $clog2(MAXS);
  localparam int SN_W = $clog2(MAXS + 1);
  localparam int AI_W = $clog2(MAXA);
  localparam int AN_W = $clog2(MAXA + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [SN_W-1:0] cfg_num_slopes = '0;
  logic [AN_W-1:0] cfg_num_act = '0;
  logic signed [11:0] cfg_gain = '0;
  logic mat_wr_en = 1'b0;
  logic [SI_W-1:0] mat_wr_slope = '0;
  logic [AI_W-1:0] mat_wr_act = '0;
  logic signed [11:0] mat_wr_data = '0;
  logic mat_swap_req = 1'b0;
  logic cal_wr_en = 1'b0;
  logic [AI_W-1:0] cal_wr_act = '0;
  logic signed [15:0] cal_wr_data = '0;
  logic frame_start = 1'b0, slope_valid = 1'b0;
  logic signed [11:0] slope_data = '0;
  logic frame_idle, drv_valid, frame_done, active_bank;
  logic [AI_W-1:0] drv_idx;
  logic signed [31:0] err_data;
  logic signed [15:0] drv_data;

  colwise_recon u_colwise_recon (
    .clk(clk), .rst_n(rst_n), .cfg_num_slopes(cfg_num_slopes), .cfg_num_act(cfg_num_act),
    .cfg_gain(cfg_gain), .mat_wr_en(mat_wr_en), .mat_wr_slope(mat_wr_slope),
    .mat_wr_act(mat_wr_act), .mat_wr_data(mat_wr_data), .mat_swap_req(mat_swap_req),
    .cal_wr_en(cal_wr_en), .cal_wr_act(cal_wr_act), .cal_wr_data(cal_wr_data),
    .frame_start(frame_start), .frame_idle(frame_idle), .slope_valid(slope_valid),
    .slope_data(slope_data), .drv_valid(drv_valid), .drv_idx(drv_idx),
    .err_data(err_data), .drv_data(drv_data), .frame_done(frame_done),
    .active_bank(active_bank)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int mdl_m [2][MAXS][MAXA];
  int mdl_cal [MAXA];
  longint mdl_drv [MAXA];
  bit mdl_bank = 1'b0, mdl_pend = 1'b0;

  int cyc = 0, n_got = 0, last_valid_cyc = 0, done_cyc = 0;
  bit done_seen = 1'b0;
  int got_idx [64];
  longint got_err [64];
  longint got_drv [64];

  always @(negedge clk) begin
    cyc++;
    if (drv_valid && n_got < 64) begin
      got_idx[n_got] = int'(drv_idx);
      got_err[n_got] = longint'(err_data);
      got_drv[n_got] = longint'(drv_data);
      n_got++;
      last_valid_cyc = cyc;
    end
    if (frame_done) begin
      done_seen = 1'b1;
      done_cyc = cyc;
    end
  end

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish (actual hang, expected completion)");
    summary_and_end();
  end

  task automatic chk(bit ok, string req, string what, longint got, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int slope_val(int seed, int s);
    return ((seed * 29 + s * 17) % 401) - 200;
  endfunction
  function automatic int coef_val(int seed, int s, int a);
    return ((seed * 7 + s * 13 + a * 5) % 121) - 60;
  endfunction
  function automatic longint floor256(longint p);
    longint q = p / 256;
    if (p < 0 && (p % 256) != 0) q = q - 1;
    return q;
  endfunction
  function automatic longint clip16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic wr_coef(int s, int a, int v);
    @(negedge clk);
    mat_wr_en = 1'b1; mat_wr_slope = SI_W'(s); mat_wr_act = AI_W'(a); mat_wr_data = 12'(v);
    mdl_m[!mdl_bank][s][a] = v;
    @(negedge clk);
    mat_wr_en = 1'b0;
  endtask

  task automatic load_shadow(int seed);
    for (int s = 0; s < MAXS; s++)
      for (int a = 0; a < MAXA; a++) wr_coef(s, a, coef_val(seed, s, a));
  endtask

  task automatic pulse_swap();
    @(negedge clk);
    mat_swap_req = 1'b1; mdl_pend = 1'b1;
    @(negedge clk);
    mat_swap_req = 1'b0;
  endtask

  task automatic wr_cal(int a, int v);
    @(negedge clk);
    cal_wr_en = 1'b1; cal_wr_act = AI_W'(a); cal_wr_data = 16'(v);
    mdl_cal[a] = v;
    @(negedge clk);
    cal_wr_en = 1'b0;
  endtask

  task automatic run_frame(int ns, int na, int seed, int extra, bit junk,
                           bit wr_during, bit swap_during, bit busy_start, string tag);
    bit fbank;
    int guard;
    longint e, d;
    @(negedge clk);
    cfg_num_slopes = SN_W'(ns); cfg_num_act = AN_W'(na);
    if (junk) begin // R9: beats while idle must be ignored
      slope_valid = 1'b1; slope_data = 12'sd2047;
      @(negedge clk);
      @(negedge clk);
      slope_valid = 1'b0;
    end
    @(negedge clk);
    n_got = 0; done_seen = 1'b0;
    frame_start = 1'b1;
    if (mdl_pend) begin mdl_bank = !mdl_bank; mdl_pend = 1'b0; end
    fbank = mdl_bank;
    @(negedge clk);
    frame_start = 1'b0;
    chk(frame_idle == 1'b0, "R8", {tag, " idle low after start"}, frame_idle, 0);
    chk(active_bank == fbank, "R7", {tag, " bank at start"}, active_bank, fbank);
    for (int s = 0; s < ns + extra; s++) begin
      slope_valid = 1'b1;
      slope_data = (s < ns) ? 12'(slope_val(seed, s)) : 12'sd1999;
      if (wr_during) begin // R6: shadow writes during the frame
        mat_wr_en = 1'b1; mat_wr_slope = SI_W'(s % MAXS); mat_wr_act = AI_W'(s % MAXA);
        mat_wr_data = 12'(50 + s);
        mdl_m[!mdl_bank][s % MAXS][s % MAXA] = 50 + s;
      end
      if (swap_during && s == 0) begin mat_swap_req = 1'b1; mdl_pend = 1'b1; end
      @(negedge clk);
      mat_swap_req = 1'b0; mat_wr_en = 1'b0;
    end
    slope_valid = 1'b0;
    if (busy_start) begin
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
    end
    guard = 0;
    while (!done_seen && guard < 600) begin @(negedge clk); #1; guard++; end
    #1;
    chk(done_seen, "R8", {tag, " frame_done seen"}, done_seen, 1);
    chk(n_got == MAXA, "R4", {tag, " beat count"}, n_got, MAXA);
    chk(done_cyc == last_valid_cyc + 1, "R8", {tag, " done one cycle after last beat"},
        done_cyc - last_valid_cyc, 1);
    for (int a = 0; a < MAXA; a++) begin
      if (a < na) begin
        e = mdl_cal[a];
        for (int s = 0; s < ns; s++) e += longint'(slope_val(seed, s)) * mdl_m[fbank][s][a];
        d = clip16(mdl_drv[a] + floor256(e * longint'(cfg_gain)));
      end else begin
        e = 0; d = 0;
      end
      mdl_drv[a] = d;
      if (a < n_got) begin
        chk(got_idx[a] == a, "R4", {tag, " index order"}, got_idx[a], a);
        chk(got_err[a] == e, (a < na) ? (ns == 0 ? "R10" : "R2") : "R5",
            $sformatf("%s err[%0d]", tag, a), got_err[a], e);
        chk(got_drv[a] == d, (a < na) ? "R3" : "R5",
            $sformatf("%s drv[%0d]", tag, a), got_drv[a], d);
      end
    end
    if (swap_during)
      chk(active_bank == fbank, "R7", {tag, " bank held after mid-frame request"}, active_bank, fbank);
    if (busy_start) begin
      repeat (4) @(negedge clk);
      #1;
      chk(frame_idle == 1'b1, "R8", {tag, " early start ignored, idle"}, frame_idle, 1);
      chk(n_got == MAXA, "R8", {tag, " no second frame"}, n_got, MAXA);
    end
  endtask

  task automatic t_reset();
    chk(frame_idle == 1'b1, "R1", "reset idle", frame_idle, 1);
    chk(drv_valid == 1'b0, "R1", "reset drv_valid", drv_valid, 0);
    chk(frame_done == 1'b0, "R1", "reset frame_done", frame_done, 0);
    chk(active_bank == 1'b0, "R1", "reset bank", active_bank, 0);
  endtask

  task automatic t_basic();
    load_shadow(1);
    pulse_swap();
    for (int a = 0; a < MAXA; a++) wr_cal(a, a * 37 - 250);
    cfg_gain = 12'sd64;
    run_frame(MAXS, MAXA, 3, 0, 0, 0, 0, 0, "basic");
    cfg_gain = -12'sd100;
    run_frame(MAXS, MAXA, 8, 0, 0, 0, 0, 0, "basic2");
  endtask

  task automatic t_partial();
    cfg_gain = 12'sd200;
    run_frame(10, 5, 5, 3, 1, 0, 0, 0, "partial");
  endtask

  task automatic t_shadow();
    load_shadow(4);
    cfg_gain = 12'sd32;
    run_frame(12, MAXA, 6, 0, 0, 1, 1, 0, "shadow_wr");
    pulse_swap();
    pulse_swap();
    run_frame(MAXS, MAXA, 7, 0, 0, 0, 0, 0, "after_swap");
    run_frame(MAXS, MAXA, 9, 0, 0, 0, 0, 0, "no_swap");
  endtask

  task automatic t_zero_slopes();
    cfg_gain = 12'sd128;
    run_frame(0, 12, 2, 2, 0, 0, 0, 0, "zero_slopes");
  endtask

  task automatic t_busy();
    cfg_gain = 12'sd16;
    run_frame(6, MAXA, 11, 0, 0, 0, 0, 1, "busy_start");
  endtask

  task automatic t_saturate();
    cfg_gain = 12'sd2047;
    for (int a = 0; a < MAXA; a++) wr_cal(a, 30000);
    run_frame(0, MAXA, 1, 0, 0, 0, 0, 0, "sat_high");
    for (int a = 0; a < MAXA; a++) wr_cal(a, -30000);
    run_frame(0, MAXA, 1, 0, 0, 0, 0, 0, "sat_low");
  endtask

  initial begin
    for (int a = 0; a < MAXA; a++) begin mdl_cal[a] = 0; mdl_drv[a] = 0; end
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < MAXS; s++)
        for (int a = 0; a < MAXA; a++) mdl_m[b][s][a] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_partial();
    t_shadow();
    t_zero_slopes();
    t_busy();
    t_saturate();
    repeat (3) @(negedge clk);
    summary_and_end();
  end
endmodule